// File: doc/BRIEF.md
# Rewindable FIFO with Selectable Output Timing

This block is a single-clock, single-direction FIFO with a 36-bit data path and a power-of-two depth. Its output timing is chosen once, when a full reset ends. In standard timing a read request loads the head word into a registered output. In fall-through timing the head word is presented at the output as soon as it is stored, and a read request only discards it and brings up the next one. Two level warnings, almost-empty and almost-full, compare the fill level with offsets that are captured when the block is configured.

Two kinds of reset are available. The full reset (asynchronous, active low) clears the storage pointers and captures the configuration again. The partial reset (synchronous, active low) clears the pointers but keeps the configuration. The partial-reset input has a second use. When the rewind select is high, the same low pulse moves the read pointer back to the first location so that the stored words can be read again. The write pointer is left alone.

The write side follows valid/ready rules. A word is taken on a rising edge when `wr_valid` and `flag_in` are both high. When `flag_in` is low, the source holds its word and the block ignores `wr_valid`. The read side takes `rd_req` as a request that counts only while `flag_out` is high. Control and status pins are plain levels.

Top module: `rewind_fifo`

## Requirements
- R1: The output timing is captured from `mode_sel` (1 = fall-through, 0 = standard) on the first rising edge after `rst_n` goes high. That edge takes no traffic. Later changes of `mode_sel` have no effect until the next full reset.
- R2: In standard timing, `rd_data` takes the head word on the edge that accepts a read. It holds its value on every edge without an accepted read.
- R3: In fall-through timing, a word written into an empty FIFO appears on `rd_data` after the writing edge with no read request, and `flag_out` goes high with it. While the FIFO is empty, `rd_data` is zero.
- R4: In fall-through timing, `rd_data` moves to the next stored word only on an accepted read. Writes behind the head do not change it.
- R5: `flag_in` is high only when the block is configured and not full. It is low during full reset and during the configuration edge. `flag_out` is high exactly when at least one word is stored.
- R6: A full reset, or a partial reset (`prs_n` low with `rt_sel` low for one edge), empties the FIFO and sets `rd_data` to zero.
- R7: A partial reset keeps the captured timing mode and the captured offsets. New values on `mode_sel`, `ae_off` and `af_off` are ignored until the next full reset.
- R8: A rewind (`prs_n` low with `rt_sel` high) returns only the read pointer to the first location. The words stored since the last reset are read again in order, and later writes append after them. A rewind is meaningful while fewer than the depth's worth of words have been written since the last reset.
- R9: `almost_empty` is high when the stored count is at or below the captured empty offset. `almost_full` is high when the free space (depth minus count) is at or below the captured full offset. Valid offsets run from 1 to depth minus 4.
- R10: A write while full and a read while empty are ignored and leave the pointers, the count and `rd_data` unchanged. Traffic on an edge where `prs_n` is low is also ignored.
- R11: A write and a read on the same edge are both accepted when allowed, and the count stays the same.
- R12: After a rewind, the count equals the write position minus the read position, and `flag_out`, `almost_empty`, `almost_full` and `rd_data` reflect it from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Full reset, asynchronous, active low |
| prs_n | input | 1 | Partial reset or rewind strobe, synchronous, active low |
| rt_sel | input | 1 | Selects rewind (1) or partial reset (0) for `prs_n` |
| mode_sel | input | 1 | Timing mode to capture: 1 fall-through, 0 standard |
| ae_off | input | AW+1 (5) | Almost-empty offset to capture |
| af_off | input | AW+1 (5) | Almost-full offset to capture |
| wr_valid | input | 1 | Write data valid |
| wr_data | input | DW (36) | Write data |
| rd_req | input | 1 | Read request |
| rd_data | output | DW (36) | Output word |
| flag_in | output | 1 | Not full and configured (write ready) |
| flag_out | output | 1 | Not empty (output valid in fall-through timing) |
| almost_empty | output | 1 | Count at or below the empty offset |
| almost_full | output | 1 | Free space at or below the full offset |

## Verification
Every state change lands on the rising edge that accepts the stimulus. `flag_in`, `flag_out`, the level warnings and `rd_data` are driven by logic from registers only, so each result is due one edge after the inputs are applied. The only exception is the configuration edge, which follows the release of the full reset and takes no traffic. The bench drives its inputs on falling edges and samples every output on the next falling edge, half a period after the edge that should have produced the result. A standard-mode sequence walks fill, drain, empty and full limits from a vector table. Directed steps then cover fall-through presentation, partial reset, rewind and mode capture.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/rwf_config.sv
module rwf_config
  import rwf_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [CW-1:0] ae_off_in,
  input  logic [CW-1:0] af_off_in,
  output logic          cfg_done,
  output xfer_mode_e    mode,
  output logic [CW-1:0] ae_off_q,
  output logic [CW-1:0] af_off_q
);

  // Capture on the first edge after full reset release; hold afterwards.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      mode     <= MODE_STD;
      ae_off_q <= '0;
      af_off_q <= '0;
    end else if (!cfg_done) begin
      cfg_done <= 1'b1;
      mode     <= mode_sel ? MODE_FWFT : MODE_STD;
      ae_off_q <= ae_off_in;
      af_off_q <= af_off_in;
    end
  end

  assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> $stable(mode));

  assert_offsets_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> ($stable(ae_off_q) && $stable(af_off_q)));

endmodule

// File: rtl/rwf_pointers.sv
module rwf_pointers #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_done,
  input  logic        prs_n,
  input  logic        rt_sel,
  input  logic        wr_valid,
  input  logic        rd_req,
  output logic        wr_acc,
  output logic        rd_acc,
  output logic [AW:0] wptr,
  output logic [AW:0] rptr,
  output logic [AW:0] count,
  output logic        full,
  output logic        empty
);

  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  assign count  = wptr - rptr;
  assign full   = (count == DEPTH_V);
  assign empty  = (count == '0);
  assign wr_acc = cfg_done && prs_n && wr_valid && !full;
  assign rd_acc = cfg_done && prs_n && rd_req && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (!prs_n) begin
      rptr <= '0;
      if (!rt_sel) wptr <= '0;
    end else begin
      if (wr_acc) wptr <= wptr + 1'b1;
      if (rd_acc) rptr <= rptr + 1'b1;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_V);

  assert_full_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prs_n && full) |=> $stable(wptr));

  assert_empty_read_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prs_n && empty) |=> $stable(rptr));

  assert_partial_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!prs_n && !rt_sel) |=> (wptr == '0 && rptr == '0));

  assert_rewind_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!prs_n && rt_sel) |=> (rptr == '0 && $stable(wptr)));

  assert_both_keep_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_acc) |=> $stable(count));

endmodule

// File: rtl/rwf_storage.sv
module rwf_storage
  import rwf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prs_n,
  input  logic          rt_sel,
  input  xfer_mode_e    mode,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          empty,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] raddr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] out_q;
  logic [DW-1:0] head;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_acc && waddr == AW'(i)) mem[i] <= wr_data;
    end
  end

  assign head = mem[raddr];

  // Standard timing: registered output, loaded only by an accepted read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (!prs_n && !rt_sel) begin
      out_q <= '0;
    end else if (rd_acc && mode == MODE_STD) begin
      out_q <= head;
    end
  end

  always_comb begin
    if (mode == MODE_FWFT) rd_data = empty ? '0 : head;
    else                   rd_data = out_q;
  end

  assert_std_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STD && prs_n && !rd_acc) |=> $stable(rd_data));

  assert_fwft_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && !empty && prs_n && !rd_acc) |=> $stable(rd_data));

endmodule

// File: rtl/rwf_levels.sv
module rwf_levels #(
  parameter int AW = 4
) (
  input  logic [AW:0] count,
  input  logic [AW:0] ae_off,
  input  logic [AW:0] af_off,
  output logic        almost_empty,
  output logic        almost_full
);

  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [AW:0] space;

  assign space        = DEPTH_V - count;
  assign almost_empty = (count <= ae_off);
  assign almost_full  = (space <= af_off);

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rwf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 4,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prs_n,
  input  logic          rt_sel,
  input  logic          mode_sel,
  input  logic [CW-1:0] ae_off,
  input  logic [CW-1:0] af_off,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          flag_in,
  output logic          flag_out,
  output logic          almost_empty,
  output logic          almost_full
);

  logic          cfg_done;
  xfer_mode_e    mode;
  logic [CW-1:0] ae_q, af_q;
  logic          wr_acc, rd_acc, full, empty;
  logic [AW:0]   wptr, rptr, count;

  rwf_config #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .ae_off_in(ae_off), .af_off_in(af_off),
    .cfg_done(cfg_done), .mode(mode), .ae_off_q(ae_q), .af_off_q(af_q)
  );

  rwf_pointers #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .prs_n(prs_n),
    .rt_sel(rt_sel), .wr_valid(wr_valid), .rd_req(rd_req),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wptr(wptr), .rptr(rptr),
    .count(count), .full(full), .empty(empty)
  );

  rwf_storage #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .prs_n(prs_n), .rt_sel(rt_sel), .mode(mode),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .empty(empty),
    .waddr(wptr[AW-1:0]), .raddr(rptr[AW-1:0]),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  rwf_levels #(.AW(AW)) u_lvl (
    .count(count), .ae_off(ae_q), .af_off(af_q),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  assign flag_in  = cfg_done && !full;
  assign flag_out = !empty;

  assert_no_write_unready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_in && prs_n) |=> $stable(wptr));

endmodule

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 36;
  localparam int CW = AW + 1;
  localparam int WATCHDOG = 5000;

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [DW-1:0] din;
    logic          fin;
    logic          fout;
    logic          ae;
    logic          af;
    logic [DW-1:0] dout;
  } vec_t;

  // Standard timing, depth 8, offsets 2/2
  localparam vec_t VECS [18] = '{
    '{1'b1, 1'b0, 36'h11, 1'b1, 1'b1, 1'b1, 1'b0, 36'h00},
    '{1'b1, 1'b0, 36'h22, 1'b1, 1'b1, 1'b1, 1'b0, 36'h00},
    '{1'b1, 1'b0, 36'h33, 1'b1, 1'b1, 1'b0, 1'b0, 36'h00},
    '{1'b0, 1'b1, 36'h00, 1'b1, 1'b1, 1'b1, 1'b0, 36'h11},
    '{1'b1, 1'b1, 36'h44, 1'b1, 1'b1, 1'b1, 1'b0, 36'h22},
    '{1'b0, 1'b1, 36'h00, 1'b1, 1'b1, 1'b1, 1'b0, 36'h33},
    '{1'b0, 1'b1, 36'h00, 1'b1, 1'b0, 1'b1, 1'b0, 36'h44},
    '{1'b0, 1'b1, 36'h00, 1'b1, 1'b0, 1'b1, 1'b0, 36'h44},
    '{1'b1, 1'b0, 36'h50, 1'b1, 1'b1, 1'b1, 1'b0, 36'h44},
    '{1'b1, 1'b0, 36'h51, 1'b1, 1'b1, 1'b1, 1'b0, 36'h44},
    '{1'b1, 1'b0, 36'h52, 1'b1, 1'b1, 1'b0, 1'b0, 36'h44},
    '{1'b1, 1'b0, 36'h53, 1'b1, 1'b1, 1'b0, 1'b0, 36'h44},
    '{1'b1, 1'b0, 36'h54, 1'b1, 1'b1, 1'b0, 1'b0, 36'h44},
    '{1'b1, 1'b0, 36'h55, 1'b1, 1'b1, 1'b0, 1'b1, 36'h44},
    '{1'b1, 1'b0, 36'h56, 1'b1, 1'b1, 1'b0, 1'b1, 36'h44},
    '{1'b1, 1'b0, 36'h57, 1'b0, 1'b1, 1'b0, 1'b1, 36'h44},
    '{1'b1, 1'b0, 36'h58, 1'b0, 1'b1, 1'b0, 1'b1, 36'h44},
    '{1'b0, 1'b1, 36'h00, 1'b1, 1'b1, 1'b0, 1'b1, 36'h50}
  };

  logic          clk;
  logic          rst_n, prs_n, rt_sel, mode_sel;
  logic [CW-1:0] ae_off, af_off;
  logic          wr_valid, rd_req;
  logic [DW-1:0] wr_data, rd_data;
  logic          flag_in, flag_out, almost_empty, almost_full;

  int checks = 0;
  int fails  = 0;

  rewind_fifo #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .prs_n(prs_n), .rt_sel(rt_sel),
    .mode_sel(mode_sel), .ae_off(ae_off), .af_off(af_off),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .flag_in(flag_in), .flag_out(flag_out),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [DW-1:0] d, input logic r);
    wr_valid = w;
    wr_data  = d;
    rd_req   = r;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_req   = 1'b0;
  endtask

  task automatic pulse_prs(input logic rewind);
    prs_n  = 1'b0;
    rt_sel = rewind;
    @(negedge clk);
    prs_n  = 1'b1;
    rt_sel = 1'b0;
  endtask

  task automatic full_reset(input logic m, input logic [CW-1:0] ae, input logic [CW-1:0] af);
    rst_n    = 1'b0;
    mode_sel = m;
    ae_off   = ae;
    af_off   = af;
    @(negedge clk);
    @(negedge clk);
    check("R5 flag_in low in reset", 64'(flag_in), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prs_n = 1'b1; rt_sel = 1'b0; mode_sel = 1'b0;
    ae_off = 4'd2; af_off = 4'd2;
    wr_valid = 1'b0; rd_req = 1'b0; wr_data = '0;
    @(negedge clk);
    full_reset(1'b0, 4'd2, 4'd2);
    check("R6 rd_data zero after reset", 64'(rd_data), 64'h0);
    check("R5 flag_out low when empty", 64'(flag_out), 64'h0);
    check("R5 flag_in high when configured", 64'(flag_in), 64'h1);
    check("R9 almost_empty at zero", 64'(almost_empty), 64'h1);
    check("R9 almost_full clear at zero", 64'(almost_full), 64'h0);

    // Table walk: R2 R9 R10 R11
    for (int i = 0; i < 18; i++) begin
      step(VECS[i].wr, VECS[i].din, VECS[i].rd);
      check($sformatf("R2 R9 R10 R11 vector %0d", i),
            64'({flag_in, flag_out, almost_empty, almost_full, rd_data}),
            64'({VECS[i].fin, VECS[i].fout, VECS[i].ae, VECS[i].af, VECS[i].dout}));
    end

    // Fall-through timing, offsets 1/1
    full_reset(1'b1, 4'd1, 4'd1);
    check("R6 rd_data zero after full reset", 64'(rd_data), 64'h0);
    step(1'b1, 36'hA1, 1'b0);
    check("R3 first word falls through", 64'(rd_data), 64'hA1);
    check("R3 flag_out marks word", 64'(flag_out), 64'h1);
    step(1'b1, 36'hA2, 1'b0);
    check("R4 head kept on write", 64'(rd_data), 64'hA1);
    step(1'b0, '0, 1'b1);
    check("R4 read advances head", 64'(rd_data), 64'hA2);
    mode_sel = 1'b0;
    step(1'b0, '0, 1'b0);
    check("R1 mode input ignored later", 64'(rd_data), 64'hA2);
    step(1'b1, 36'hA3, 1'b1);
    check("R11 simultaneous read and write", 64'(rd_data), 64'hA3);
    check("R11 flag_out stays", 64'(flag_out), 64'h1);

    // Partial reset keeps configuration
    ae_off = 4'd5;
    pulse_prs(1'b0);
    check("R6 partial reset zeroes rd_data", 64'(rd_data), 64'h0);
    check("R6 partial reset empties", 64'(flag_out), 64'h0);
    step(1'b1, 36'hB1, 1'b0);
    check("R7 fall-through kept", 64'(rd_data), 64'hB1);
    step(1'b1, 36'hB2, 1'b0);
    check("R7 empty offset kept", 64'(almost_empty), 64'h0);

    // Rewind
    step(1'b0, '0, 1'b1);
    check("R8 second word", 64'(rd_data), 64'hB2);
    step(1'b0, '0, 1'b1);
    check("R10 drained", 64'({flag_out, rd_data}), 64'h0);
    check("R9 almost_empty when drained", 64'(almost_empty), 64'h1);
    pulse_prs(1'b1);
    check("R12 count restored after rewind", 64'({flag_out, almost_empty}), 64'h2);
    check("R8 replay starts at first word", 64'(rd_data), 64'hB1);
    step(1'b1, 36'hB3, 1'b0);
    check("R8 write appends behind", 64'(rd_data), 64'hB1);
    step(1'b0, '0, 1'b1);
    check("R8 replay second", 64'(rd_data), 64'hB2);
    step(1'b0, '0, 1'b1);
    check("R8 write pointer kept", 64'(rd_data), 64'hB3);
    step(1'b0, '0, 1'b1);
    check("R5 empty after replay", 64'(flag_out), 64'h0);

    // Back to standard timing
    full_reset(1'b0, 4'd2, 4'd2);
    check("R6 rd_data zero", 64'(rd_data), 64'h0);
    step(1'b1, 36'hC1, 1'b0);
    check("R1 standard captured, no fall-through", 64'(rd_data), 64'h0);
    check("R5 flag_out after write", 64'(flag_out), 64'h1);
    step(1'b0, '0, 1'b1);
    check("R2 read loads output", 64'(rd_data), 64'hC1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule